// File: doc/BRIEF.md
# Supply Rail Power-Up Sequencer

This controller brings up a reference and three regulated rails in a fixed chain: the reference, then the main boost converter, then the negative charge pump, and last the positive charge pump. Each rail has two comparator flags. The first says the rail has reached its power-up threshold. The second says the rail has fallen below its fault threshold. The controller starts the next rail only when the power-up flag of the rail before it is set. When the last rail is up, it asserts a drive-low enable for an open-drain ready line.

After ready is asserted, the controller watches the fault flags. If any rail faults, ready is released. The controller then switches off only the rails that follow the lowest faulted rail, and earlier rails keep running. It resumes the chain once the faulted rail reports its power-up threshold again. A low shutdown pin or an asserted input undervoltage flag turns everything off. Releasing them restarts the chain from the reference. Each time the main boost converter is switched on, the controller sends a one-cycle soft-start restart pulse to it.

Every input goes through a synchronizer of `SYNC_STAGES` flops, which is 2 by default. The flag vectors index the rails as follows: bit 0 is the reference, bit 1 is the main rail, bit 2 is the negative rail and bit 3 is the positive rail.

Top module: `rail_sequencer`

## Requirements
- R1: While reset is applied, and in the first cycle after it, all four enables, `ssRestart` and `rdyPullLow` are 0.
- R2: With shutdown released and no undervoltage, the reference enable rises first. Each later rail (bit order 0,1,2,3) is enabled on the clock edge after the synchronized power-up flag of the rail before it is seen. At most one rail is added per cycle.
- R3: `rdyPullLow` is 1 only when all four rails are enabled and the positive rail's power-up flag (bit 3) has been seen. A value of 0 means the line is high-impedance.
- R4: A rail is never enabled while any rail earlier in the chain is disabled.
- R5: `ssRestart` is high for exactly one cycle, and that cycle is the one in which `mainEn` rises, on every rise.
- R6: While ready is asserted, any set fault flag releases ready. It also disables every rail after the lowest-numbered faulted rail, and that rail and the earlier ones stay enabled.
- R7: Rails dropped by a fault stay off until the faulted rail's power-up flag is set again. The chain then resumes one rail per cycle, and ready returns after the positive rail's flag is seen.
- R8: Fault flags have no effect while ready is not asserted.
- R9: `shdnN` low or `uvlo` high disables all rails and ready on the next edge after synchronization, and holds them off. On release, the chain restarts from the reference.
- R10: An input change made between clock edges first shows at the outputs after the third following rising edge: two synchronizer edges and one state edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| shdnN | input | 1 | Active-low shutdown request |
| uvlo | input | 1 | Input undervoltage flag, active high |
| upOk | input | RAIL_CNT | Per-rail power-up threshold reached (bit 0 ref .. bit 3 positive) |
| fltLow | input | RAIL_CNT | Per-rail below-fault-threshold flag |
| refEn | output | 1 | Reference enable |
| mainEn | output | 1 | Main boost converter enable |
| negEn | output | 1 | Negative charge pump enable |
| posEn | output | 1 | Positive charge pump enable |
| ssRestart | output | 1 | One-cycle soft-start restart pulse for the main converter |
| rdyPullLow | output | 1 | Ready line drive: 1 pulls low, 0 leaves high-impedance |

## Verification
The assertions check the following on every cycle:
- The enable chain stays ordered, and no more than one rail is added per edge.
- The soft-start pulse lines up with each rise of the main enable.
- Shutdown or undervoltage clears everything.
- A fault seen while ready releases ready.
- While ready is low, rails never drop for any reason other than a halt.

The bench scenarios are needed for the following:
- The exact three-edge latency.
- The choice of the lowest faulted rail when several fault at once.
- Dropped rails staying off after the fault flag clears.
- The restart from the reference after shutdown or undervoltage.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
  parameter int RAIL_CNT = 4;
  localparam int LVL_W = $clog2(RAIL_CNT + 1);

  typedef struct packed {
    logic             clearAll;
    logic             step;
    logic             dropValid;
    logic [LVL_W-1:0] dropLevel;
    logic             readyOn;
    logic             readyOff;
  } seqCmd_t;
endpackage

// File: rtl/rail_seq_dp.sv
module rail_seq_dp
  import rseq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MAIN_IDX    = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                shdnN,
  input  logic                uvlo,
  input  logic [RAIL_CNT-1:0] upOk,
  input  logic [RAIL_CNT-1:0] fltLow,
  input  seqCmd_t             cmd,
  output logic                haltS,
  output logic [RAIL_CNT-1:0] upOkS,
  output logic [RAIL_CNT-1:0] fltS,
  output logic [LVL_W-1:0]    level,
  output logic [RAIL_CNT-1:0] railEn,
  output logic                rdy,
  output logic                ssRestart
);
  localparam int SW = 2 + 2 * RAIL_CNT;
  // synchronizer resets to "halt requested" so nothing powers up early
  localparam logic [SW-1:0] RST_VEC = SW'(1);

  logic [SW-1:0] rawVec;
  logic [SW-1:0] pipe [SYNC_STAGES];

  assign rawVec = {fltLow, upOk, uvlo, ~shdnN};

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[g] <= RST_VEC;
        else       pipe[g] <= rawVec;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[g] <= RST_VEC;
        else       pipe[g] <= pipe[g-1];
      end
    end
  end

  assign haltS = pipe[SYNC_STAGES-1][0] | pipe[SYNC_STAGES-1][1];
  assign upOkS = pipe[SYNC_STAGES-1][2 +: RAIL_CNT];
  assign fltS  = pipe[SYNC_STAGES-1][2 + RAIL_CNT +: RAIL_CNT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      level     <= '0;
      rdy       <= 1'b0;
      ssRestart <= 1'b0;
    end else begin
      ssRestart <= 1'b0;
      if (cmd.clearAll) begin
        level <= '0;
      end else if (cmd.dropValid) begin
        level <= cmd.dropLevel;
      end else if (cmd.step) begin
        level <= level + 1'b1;
        if (level == LVL_W'(MAIN_IDX)) ssRestart <= 1'b1;
      end
      if (cmd.readyOff)     rdy <= 1'b0;
      else if (cmd.readyOn) rdy <= 1'b1;
    end
  end

  for (genvar g = 0; g < RAIL_CNT; g++) begin : gEn
    assign railEn[g] = (level > LVL_W'(g));
  end

  // R4: chain ordering
  for (genvar g = 1; g < RAIL_CNT; g++) begin : gOrd
    a_r4_chain_order: assert property (@(posedge clk) disable iff (!rstN)
      railEn[g] |-> railEn[g-1]);
  end

  a_r2_one_per_cycle: assert property (@(posedge clk) disable iff (!rstN)
    $countones(railEn) <= $countones($past(railEn)) + 1);

  a_r3_ready_full_chain: assert property (@(posedge clk) disable iff (!rstN)
    rdy |-> (&railEn));

  a_r3_ready_needs_up: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdy) |-> $past(upOkS[RAIL_CNT-1]));

  a_r5_ss_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(railEn[MAIN_IDX]) |-> ssRestart);

  a_r5_ss_only_rise: assert property (@(posedge clk) disable iff (!rstN)
    ssRestart |-> $rose(railEn[MAIN_IDX]));

  a_r6_fault_drops_ready: assert property (@(posedge clk) disable iff (!rstN)
    (rdy && (|fltS) && !haltS) |=> !rdy);

  a_r8_no_drop_unready: assert property (@(posedge clk) disable iff (!rstN)
    (!rdy && !haltS) |=> ($countones(railEn) >= $countones($past(railEn))));

  a_r9_halt_clears: assert property (@(posedge clk) disable iff (!rstN)
    haltS |=> (railEn == '0 && !rdy));
endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
  import rseq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                haltS,
  input  logic [RAIL_CNT-1:0] upOkS,
  input  logic [RAIL_CNT-1:0] fltS,
  input  logic [LVL_W-1:0]    level,
  output seqCmd_t             cmd
);
  typedef enum logic [1:0] {ST_OFF, ST_RAMP, ST_READY} seqState_t;

  seqState_t state, nxtState;
  logic curUp;
  logic [LVL_W-1:0] lowLvl;

  // power-up flag of the newest enabled rail
  always_comb begin
    curUp = 1'b0;
    for (int i = 0; i < RAIL_CNT; i++)
      if (level == LVL_W'(i + 1)) curUp = upOkS[i];
  end

  // lowest faulted rail: keep it and everything before it
  always_comb begin
    lowLvl = '0;
    for (int i = RAIL_CNT - 1; i >= 0; i--)
      if (fltS[i]) lowLvl = LVL_W'(i + 1);
  end

  always_comb begin
    cmd      = '0;
    nxtState = state;
    if (haltS) begin
      cmd.clearAll = 1'b1;
      cmd.readyOff = 1'b1;
      nxtState     = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF: begin
          cmd.step = 1'b1;
          nxtState = ST_RAMP;
        end
        ST_RAMP: begin
          if (level != '0 && curUp) begin
            if (level == LVL_W'(RAIL_CNT)) begin
              cmd.readyOn = 1'b1;
              nxtState    = ST_READY;
            end else begin
              cmd.step = 1'b1;
            end
          end
        end
        ST_READY: begin
          if (|fltS) begin
            cmd.dropValid = 1'b1;
            cmd.dropLevel = lowLvl;
            cmd.readyOff  = 1'b1;
            nxtState      = ST_RAMP;
          end
        end
        default: nxtState = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= nxtState;
  end

  a_r6_drop_keeps_fault: assert property (@(posedge clk) disable iff (!rstN)
    cmd.dropValid |-> (cmd.dropLevel != '0 && fltS[cmd.dropLevel - 1'b1]));

  a_r8_quiet_when_ramping: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_READY) |-> !cmd.dropValid);
endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
  import rseq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MAIN_IDX    = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                shdnN,
  input  logic                uvlo,
  input  logic [RAIL_CNT-1:0] upOk,
  input  logic [RAIL_CNT-1:0] fltLow,
  output logic                refEn,
  output logic                mainEn,
  output logic                negEn,
  output logic                posEn,
  output logic                ssRestart,
  output logic                rdyPullLow
);
  seqCmd_t             cmd;
  logic                haltS;
  logic [RAIL_CNT-1:0] upOkS;
  logic [RAIL_CNT-1:0] fltS;
  logic [LVL_W-1:0]    level;
  logic [RAIL_CNT-1:0] railEn;
  logic                rdy;

  rail_seq_dp #(.SYNC_STAGES(SYNC_STAGES), .MAIN_IDX(MAIN_IDX)) uDp (
    .clk(clk), .rstN(rstN), .shdnN(shdnN), .uvlo(uvlo),
    .upOk(upOk), .fltLow(fltLow), .cmd(cmd),
    .haltS(haltS), .upOkS(upOkS), .fltS(fltS), .level(level),
    .railEn(railEn), .rdy(rdy), .ssRestart(ssRestart)
  );

  rail_seq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .haltS(haltS), .upOkS(upOkS),
    .fltS(fltS), .level(level), .cmd(cmd)
  );

  assign refEn      = railEn[0];
  assign mainEn     = railEn[1];
  assign negEn      = railEn[2];
  assign posEn      = railEn[3];
  assign rdyPullLow = rdy;
endmodule

// File: tb/sim_rail_sequencer.sv
module sim_rail_sequencer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic shdnN = 1'b0;
  logic uvlo = 1'b0;
  logic [3:0] upOk = '0;
  logic [3:0] fltLow = '0;
  logic refEn, mainEn, negEn, posEn, ssRestart, rdyPullLow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [3:0] en;
    logic       rdy;
    logic       ss;
    string      tag;
  } expItem_t;

  expItem_t sbQ[$];
  event chk;

  always #(CLK_PERIOD/2) clk = ~clk;

  rail_sequencer u0 (
    .clk(clk), .rstN(rstN), .shdnN(shdnN), .uvlo(uvlo),
    .upOk(upOk), .fltLow(fltLow),
    .refEn(refEn), .mainEn(mainEn), .negEn(negEn), .posEn(posEn),
    .ssRestart(ssRestart), .rdyPullLow(rdyPullLow)
  );

  // monitor: pops expected items and compares with the ports
  initial begin
    forever begin
      @(chk);
      while (sbQ.size() > 0) begin
        expItem_t e;
        logic [3:0] act;
        e = sbQ.pop_front();
        act = {posEn, negEn, mainEn, refEn};
        checks++;
        if (act !== e.en || rdyPullLow !== e.rdy || ssRestart !== e.ss) begin
          errors++;
          $display("FAIL %s: actual en=%b rdy=%b ss=%b expected en=%b rdy=%b ss=%b",
                   e.tag, act, rdyPullLow, ssRestart, e.en, e.rdy, e.ss);
        end
      end
    end
  end

  task automatic drive(input logic [3:0] up, input logic [3:0] flt,
                       input logic sd, input logic uv);
    @(negedge clk);
    upOk = up; fltLow = flt; shdnN = sd; uvlo = uv;
  endtask

  task automatic expectAfter(input int cyc, input logic [3:0] en,
                             input logic rdy, input logic ss, input string tag);
    expItem_t e;
    repeat (cyc) @(negedge clk);
    e.en = en; e.rdy = rdy; e.ss = ss; e.tag = tag;
    sbQ.push_back(e);
    ->chk;
  endtask

  task automatic fullRamp(input string tag);
    expectAfter(3, 4'b0001, 1'b0, 1'b0, tag);
    expectAfter(1, 4'b0011, 1'b0, 1'b1, tag);
    expectAfter(1, 4'b0111, 1'b0, 1'b0, tag);
    expectAfter(1, 4'b1111, 1'b0, 1'b0, tag);
    expectAfter(1, 4'b1111, 1'b1, 1'b0, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    expectAfter(0, 4'b0000, 1'b0, 1'b0, "R1 reset");
    @(negedge clk);
    rstN = 1'b1; shdnN = 1'b1;
    expectAfter(1, 4'b0000, 1'b0, 1'b0, "R1 after reset");
    // R10 latency, R2 reference first
    expectAfter(1, 4'b0000, 1'b0, 1'b0, "R10 before sync");
    expectAfter(1, 4'b0001, 1'b0, 1'b0, "R2 reference first");
    // R2/R5 main rail
    drive(4'b0001, 4'b0000, 1'b1, 1'b0);
    expectAfter(2, 4'b0001, 1'b0, 1'b0, "R10 main not yet");
    expectAfter(1, 4'b0011, 1'b0, 1'b1, "R5 ss with main");
    expectAfter(1, 4'b0011, 1'b0, 1'b0, "R5 single pulse");
    // R8 fault ignored during ramp
    drive(4'b0001, 4'b0011, 1'b1, 1'b0);
    expectAfter(3, 4'b0011, 1'b0, 1'b0, "R8 fault ignored");
    drive(4'b0001, 4'b0000, 1'b1, 1'b0);
    expectAfter(3, 4'b0011, 1'b0, 1'b0, "R8 still ramping");
    // R2 negative then positive
    drive(4'b0011, 4'b0000, 1'b1, 1'b0);
    expectAfter(3, 4'b0111, 1'b0, 1'b0, "R2 negative rail");
    drive(4'b0111, 4'b0000, 1'b1, 1'b0);
    expectAfter(3, 4'b1111, 1'b0, 1'b0, "R2 positive rail");
    expectAfter(2, 4'b1111, 1'b0, 1'b0, "R3 no ready without pos up");
    drive(4'b1111, 4'b0000, 1'b1, 1'b0);
    expectAfter(3, 4'b1111, 1'b1, 1'b0, "R3 ready asserted");
    // R6 negative fault drops positive only
    drive(4'b1011, 4'b0100, 1'b1, 1'b0);
    expectAfter(3, 4'b0111, 1'b0, 1'b0, "R6 negative fault");
    drive(4'b1011, 4'b0000, 1'b1, 1'b0);
    expectAfter(3, 4'b0111, 1'b0, 1'b0, "R7 held until up");
    drive(4'b1111, 4'b0000, 1'b1, 1'b0);
    expectAfter(3, 4'b1111, 1'b0, 1'b0, "R7 resume");
    expectAfter(1, 4'b1111, 1'b1, 1'b0, "R7 ready back");
    // R6 two faults: lowest wins
    drive(4'b0101, 4'b1010, 1'b1, 1'b0);
    expectAfter(3, 4'b0011, 1'b0, 1'b0, "R6 lowest fault");
    drive(4'b1111, 4'b0000, 1'b1, 1'b0);
    expectAfter(3, 4'b0111, 1'b0, 1'b0, "R7 resume neg");
    expectAfter(1, 4'b1111, 1'b0, 1'b0, "R7 resume pos");
    expectAfter(1, 4'b1111, 1'b1, 1'b0, "R7 ready again");
    // R6 reference fault, R5 soft-start on re-enable
    drive(4'b1110, 4'b0001, 1'b1, 1'b0);
    expectAfter(3, 4'b0001, 1'b0, 1'b0, "R6 reference fault");
    drive(4'b1111, 4'b0000, 1'b1, 1'b0);
    expectAfter(3, 4'b0011, 1'b0, 1'b1, "R5 ss after fault");
    expectAfter(1, 4'b0111, 1'b0, 1'b0, "R7 chain neg");
    expectAfter(1, 4'b1111, 1'b0, 1'b0, "R7 chain pos");
    expectAfter(1, 4'b1111, 1'b1, 1'b0, "R7 chain ready");
    // R6 positive fault: rails stay, ready drops
    drive(4'b0111, 4'b1000, 1'b1, 1'b0);
    expectAfter(3, 4'b1111, 1'b0, 1'b0, "R6 positive fault");
    drive(4'b1111, 4'b0000, 1'b1, 1'b0);
    expectAfter(3, 4'b1111, 1'b1, 1'b0, "R7 positive back");
    // R9 undervoltage
    drive(4'b1111, 4'b0000, 1'b1, 1'b1);
    expectAfter(3, 4'b0000, 1'b0, 1'b0, "R9 undervoltage off");
    drive(4'b1111, 4'b0000, 1'b1, 1'b0);
    fullRamp("R9 restart after uvlo");
    // R9 shutdown
    drive(4'b1111, 4'b0000, 1'b0, 1'b0);
    expectAfter(3, 4'b0000, 1'b0, 1'b0, "R9 shutdown off");
    expectAfter(5, 4'b0000, 1'b0, 1'b0, "R9 shutdown held");
    drive(4'b1111, 4'b0000, 1'b1, 1'b0);
    fullRamp("R9 restart after shutdown");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule